// File: doc/BRIEF.md
# Colour Lookup Table Loader with Sequenced Data Port

This block holds a colour lookup table of 256 entries. Each entry has separate 8-bit red, green and blue fields. A host loads the table through two byte-addressed registers. The first sets the entry pointer. The second is a data port that takes colour components one after another. Each component fills the next colour slot of the current entry. After the blue slot the pointer advances to the next entry.

The data port takes single bytes or 32-bit words. A word is split into four components, most significant byte first, so one word can finish one entry and begin the next. A scanout engine reads the table through a separate lookup port. It presents an 8-bit pixel value and receives the packed 24-bit colour one cycle later. Every store through the data port raises a redraw request, which the display side acknowledges once it has consumed it.

Top module: `clut_wr_seq`

## Requirements
- R1: A host write to offset 0x0 loads the entry pointer from `host_wdata[7:0]` and returns the component phase to red, even when a sequence is part-way through.
- R2: A 1-byte data-port write (`host_size`=0, offset 0x4) stores `host_wdata[7:0]` into the current entry. Successive such writes fill red, then green, then blue.
- R3: Storing a blue component advances the entry pointer by one, wrapping from 255 to 0, and the next component is red.
- R4: A 4-byte data-port write (`host_size`=1) supplies four components in the order bits 31:24, 23:16, 15:8, 7:0. Each continues the red/green/blue sequence, so one write can cross into the next entry.
- R5: `host_rdata` reads as zero at both offsets.
- R6: A data-port write sets `redraw_req` from the following cycle. `redraw_ack` clears it. When a data-port write and an acknowledge fall in the same cycle, the flag stays set.
- R7: Reset clears every entry to zero, puts the phase at red and clears `redraw_req`.
- R8: One cycle after `pix_in` equals p, `pix_rgb` equals {red[p], green[p], blue[p]}, packed as bits 23:16, 15:8 and 7:0.
- R9: When a store and a lookup hit the same entry in the same cycle, that lookup returns the previous value. The new value appears on the next lookup.
- R10: Writes to offsets other than 0x0 and 0x4 change neither the table, the pointer, the phase nor `redraw_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host byte offset |
| host_size | input | 1 | Access size: 0 = one byte, 1 = four bytes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (always zero) |
| redraw_ack | input | 1 | Display side has consumed the redraw request |
| redraw_req | output | 1 | Table changed since the last acknowledge |
| pix_in | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Packed colour for the previous cycle's pixel value |

## Verification
The assertions assume that a host write strobe lasts exactly one cycle per access. They also assume the pointer write and the data-port write are never signalled in the same cycle, which holds because they sit at different offsets. They further assume `host_size` is meaningful only on data-port writes. The stimulus issues each access as a single-cycle strobe driven between clock edges. It mixes byte and word writes from every starting phase, and it times acknowledges both alone and together with data-port writes, so the flag priority is exercised without breaking those assumptions.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq #(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int LANES  = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               idx_ld,
   input  logic [IDX_W-1:0]                   idx_val,
   input  logic                               dat_we,
   input  logic                               dat_wide,
   input  logic [LANES*COMP_W-1:0]            dat_bus,
   output logic [LANES-1:0]                   lane_en,
   output logic [LANES-1:0][1:0]              lane_ph,
   output logic [LANES-1:0][IDX_W-1:0]        lane_idx,
   output logic [LANES-1:0][COMP_W-1:0]       lane_dat
);
   import clut_pkg::*;

   localparam int SUM_W = $clog2(LANES + 3) + 1;

   logic [IDX_W-1:0] cur_idx;
   logic [1:0]       cur_ph;
   logic [SUM_W-1:0] step_sum;
   logic [IDX_W-1:0] nxt_idx;
   logic [1:0]       nxt_ph;

   if (LANES < 1) begin : g_bad_lanes
      $error("clut_seq: LANES must be at least 1");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SUM_W-1:0] pos;
      assign pos         = SUM_W'(cur_ph) + SUM_W'(k);
      assign lane_ph[k]  = 2'(pos % SUM_W'(3));
      assign lane_idx[k] = cur_idx + IDX_W'(pos / SUM_W'(3));
      if (k == 0) begin : g_first
         assign lane_en[k]  = dat_we;
         assign lane_dat[k] = dat_wide ? dat_bus[(LANES-1)*COMP_W +: COMP_W]
                                       : dat_bus[COMP_W-1:0];
      end else begin : g_rest
         assign lane_en[k]  = dat_we & dat_wide;
         assign lane_dat[k] = dat_bus[(LANES-1-k)*COMP_W +: COMP_W];
      end
   end

   always_comb begin
      step_sum = SUM_W'(cur_ph) + (dat_wide ? SUM_W'(LANES) : SUM_W'(1));
      nxt_ph   = 2'(step_sum % SUM_W'(3));
      nxt_idx  = cur_idx + IDX_W'(step_sum / SUM_W'(3));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx <= '0;
         cur_ph  <= PH_RED;
      end else if (idx_ld) begin
         cur_idx <= idx_val;
         cur_ph  <= PH_RED;
      end else if (dat_we) begin
         cur_idx <= nxt_idx;
         cur_ph  <= nxt_ph;
      end
   end

   assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idx_ld |=> (cur_idx == $past(idx_val) && cur_ph == PH_RED));

   assert_red_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !dat_wide && !idx_ld && cur_ph == PH_RED)
      |=> (cur_ph == PH_GRN && $stable(cur_idx)));

   assert_blue_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !dat_wide && !idx_ld && cur_ph == PH_BLU)
      |=> (cur_ph == PH_RED && cur_idx == IDX_W'($past(cur_idx) + 1'b1)));
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
   parameter int         IDX_W  = 8,
   parameter int         COMP_W = 8,
   parameter int         LANES  = 4,
   parameter logic [1:0] SEL    = 2'd0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             lane_en,
   input  logic [LANES-1:0][1:0]        lane_ph,
   input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
   input  logic [LANES-1:0][COMP_W-1:0] lane_dat,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [COMP_W-1:0]            rd_dat
);
   localparam int DEPTH = 1 << IDX_W;

   logic [COMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
         rd_dat <= '0;
      end else begin
         rd_dat <= mem[rd_idx];
         for (int k = 0; k < LANES; k++) begin
            if (lane_en[k] && lane_ph[k] == SEL) mem[lane_idx[k]] <= lane_dat[k];
         end
      end
   end
endmodule

// File: rtl/clut_wr_seq.sv
module clut_wr_seq #(
   parameter int         IDX_W    = 8,
   parameter int         COMP_W   = 8,
   parameter int         HOST_DW  = 32,
   parameter int         ADDR_W   = 3,
   parameter logic [2:0] OFF_IDX  = 3'h0,
   parameter logic [2:0] OFF_DATA = 3'h4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_we,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic                host_size,
   input  logic [HOST_DW-1:0]  host_wdata,
   output logic [HOST_DW-1:0]  host_rdata,
   input  logic                redraw_ack,
   output logic                redraw_req,
   input  logic [IDX_W-1:0]    pix_in,
   output logic [3*COMP_W-1:0] pix_rgb
);
   localparam int LANES = HOST_DW / COMP_W;

   if (HOST_DW % COMP_W != 0) begin : g_bad_dw
      $error("clut_wr_seq: HOST_DW must be a multiple of COMP_W");
   end
   if (IDX_W > COMP_W) begin : g_bad_idx
      $error("clut_wr_seq: pointer must fit in one host byte");
   end

   logic                         idx_ld;
   logic                         dat_we;
   logic [LANES-1:0]             lane_en;
   logic [LANES-1:0][1:0]        lane_ph;
   logic [LANES-1:0][IDX_W-1:0]  lane_idx;
   logic [LANES-1:0][COMP_W-1:0] lane_dat;

   assign idx_ld     = host_we && host_addr == ADDR_W'(OFF_IDX);
   assign dat_we     = host_we && host_addr == ADDR_W'(OFF_DATA);
   assign host_rdata = '0;

   clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_ld   (idx_ld),
      .idx_val  (host_wdata[IDX_W-1:0]),
      .dat_we   (dat_we),
      .dat_wide (host_size),
      .dat_bus  (host_wdata),
      .lane_en  (lane_en),
      .lane_ph  (lane_ph),
      .lane_idx (lane_idx),
      .lane_dat (lane_dat)
   );

   for (genvar c = 0; c < 3; c++) begin : g_bank
      clut_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES), .SEL(2'(c))) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .lane_en  (lane_en),
         .lane_ph  (lane_ph),
         .lane_idx (lane_idx),
         .lane_dat (lane_dat),
         .rd_idx   (pix_in),
         .rd_dat   (pix_rgb[(2-c)*COMP_W +: COMP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          redraw_req <= 1'b0;
      else if (dat_we)     redraw_req <= 1'b1;
      else if (redraw_ack) redraw_req <= 1'b0;
   end

   assert_redraw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == ADDR_W'(OFF_DATA)) |=> redraw_req);

   assert_redraw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (redraw_ack && !host_we) |=> !redraw_req);

   assert_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr != ADDR_W'(OFF_DATA) && !redraw_ack) |=> $stable(redraw_req));
endmodule

// File: tb/sim_clut_wr_seq.sv
module sim_clut_wr_seq;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_size = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        redraw_ack = 1'b0;
   logic        redraw_req;
   logic [7:0]  pix_in = '0;
   logic [23:0] pix_rgb;

   int checks = 0;
   int fails  = 0;
   logic [7:0] m_r [256];
   logic [7:0] m_g [256];
   logic [7:0] m_b [256];
   int m_idx = 0;
   int m_ph  = 0;
   logic [23:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_NS/2) clk = ~clk;

   clut_wr_seq u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .redraw_ack(redraw_ack), .redraw_req(redraw_req),
      .pix_in(pix_in), .pix_rgb(pix_rgb)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_byte(input logic [7:0] b);
      case (m_ph)
         0: m_r[m_idx] = b;
         1: m_g[m_idx] = b;
         default: m_b[m_idx] = b;
      endcase
      m_ph++;
      if (m_ph == 3) begin
         m_ph  = 0;
         m_idx = (m_idx + 1) & 255;
      end
   endtask

   task automatic model_wr(input logic [2:0] a, input logic sz, input logic [31:0] d);
      if (a == 3'h0) begin
         m_idx = int'(d[7:0]);
         m_ph  = 0;
      end else if (a == 3'h4) begin
         if (sz) for (int k = 3; k >= 0; k--) model_byte(d[k*8 +: 8]);
         else model_byte(d[7:0]);
      end
   endtask

   // driver: one host write, optional acknowledge in the same cycle
   task automatic wr(input logic [2:0] a, input logic sz, input logic [31:0] d, input logic ack);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_size = sz; host_wdata = d; redraw_ack = ack;
      #1 chk(host_rdata == 32'h0, "R5", host_rdata, 32'h0);
      model_wr(a, sz, d);
      @(negedge clk);
      host_we = 1'b0; redraw_ack = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      redraw_ack = 1'b1;
      @(negedge clk);
      redraw_ack = 1'b0;
   endtask

   task automatic look(input int p, input string req);
      @(negedge clk);
      pix_in = 8'(p);
      exp_q.push_back({m_r[p], m_g[p], m_b[p]});
      tag_q.push_back(req);
   endtask

   // same-cycle store and lookup of one entry (R9)
   task automatic wr_look(input logic [7:0] b, input int p);
      @(negedge clk);
      host_we = 1'b1; host_addr = 3'h4; host_size = 1'b0; host_wdata = {24'h0, b};
      pix_in = 8'(p);
      exp_q.push_back({m_r[p], m_g[p], m_b[p]});
      tag_q.push_back("R9 old");
      model_wr(3'h4, 1'b0, {24'h0, b});
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // monitor: compare lookup results one cycle after presentation (R8)
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [23:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(pix_rgb == e, t, {8'h0, pix_rgb}, {8'h0, e});
      end
   end

   initial begin
      #(CLK_NS * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin m_r[i] = 0; m_g[i] = 0; m_b[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state
      chk(redraw_req == 1'b0, "R7 redraw", {31'h0, redraw_req}, 32'h0);
      chk(host_rdata == 32'h0, "R5 idle", host_rdata, 32'h0);
      for (int i = 0; i < 256; i++) look(i, "R7 clear");

      // R1 R2: byte writes fill red, green, blue
      wr(3'h0, 1'b0, 32'h05, 1'b0);
      wr(3'h4, 1'b0, 32'h11, 1'b0);
      wr(3'h4, 1'b0, 32'h22, 1'b0);
      wr(3'h4, 1'b0, 32'h33, 1'b0);
      look(5, "R2 entry5");
      chk(redraw_req == 1'b1, "R6 set", {31'h0, redraw_req}, 32'h1);
      ack_pulse();
      chk(redraw_req == 1'b0, "R6 clear", {31'h0, redraw_req}, 32'h0);

      // R3: wrap from 255 to 0
      wr(3'h0, 1'b0, 32'hFF, 1'b0);
      wr(3'h4, 1'b0, 32'hA1, 1'b0);
      wr(3'h4, 1'b0, 32'hA2, 1'b0);
      wr(3'h4, 1'b0, 32'hA3, 1'b0);
      wr(3'h4, 1'b0, 32'hB1, 1'b0);
      wr(3'h4, 1'b0, 32'hB2, 1'b0);
      wr(3'h4, 1'b0, 32'hB3, 1'b0);
      look(255, "R3 last");
      look(0, "R3 wrap");

      // R4: word writes crossing entries from red and from green phase
      wr(3'h0, 1'b0, 32'h0A, 1'b0);
      wr(3'h4, 1'b1, 32'hAABBCCDD, 1'b0);
      wr(3'h4, 1'b1, 32'h01020304, 1'b0);
      wr(3'h4, 1'b0, 32'h55, 1'b0);
      look(10, "R4 e10");
      look(11, "R4 e11");
      look(12, "R4 e12");
      wr(3'h4, 1'b1, 32'h90919293, 1'b0);
      look(13, "R4 e13");
      look(14, "R4 e14");

      // R1: pointer write mid-sequence restarts at red
      wr(3'h0, 1'b0, 32'h14, 1'b0);
      wr(3'h4, 1'b0, 32'h77, 1'b0);
      wr(3'h0, 1'b0, 32'h15, 1'b0);
      wr(3'h4, 1'b0, 32'h88, 1'b0);
      look(20, "R1 e20");
      look(21, "R1 e21");

      // R10: stray offsets touch nothing
      ack_pulse();
      wr(3'h2, 1'b1, 32'hDEADBEEF, 1'b0);
      wr(3'h6, 1'b0, 32'h000000EE, 1'b0);
      chk(redraw_req == 1'b0, "R10 redraw", {31'h0, redraw_req}, 32'h0);
      wr(3'h4, 1'b0, 32'h99, 1'b0);
      look(21, "R10 phase kept");
      look(22, "R10 neighbour");

      // R6: write and acknowledge together keeps the flag
      ack_pulse();
      wr(3'h4, 1'b0, 32'h66, 1'b1);
      chk(redraw_req == 1'b1, "R6 priority", {31'h0, redraw_req}, 32'h1);

      // R9: store and lookup of one entry in one cycle
      wr(3'h0, 1'b0, 32'h30, 1'b0);
      wr_look(8'h5A, 48);
      look(48, "R9 new");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule